// File: doc/BRIEF.md
# Microprogrammed memory cycle sequencer

This block produces the control waveforms for a DRAM-style memory device from a small writable array of control words. Software fills the array and sets a few options through a single mode register. When a bus access or a refresh is started, the sequencer reads one control word per clock. It begins at a start offset fixed for each pattern type. Each word sets chip-select, the byte strobes and the address-mux select. It also carries control bits that acknowledge the transfer, end the pattern, arm a hold-off timer, repeat the word, or make the word wait on an external wait input.

A pattern ends with the word that has its end bit set. If another start is pending at that point, the next pattern begins in the very next cycle. Otherwise the outputs go idle. A word that has both the end bit and the hold-off bit set loads a disable timer, and no new pattern may start until that timer has run out. A programmable refresh timer raises refresh requests. A pending refresh wins over every other start at a pattern boundary.

Top module: `mcyc_seq`

## Requirements
- R1: After reset, and whenever no pattern runs, cs_o, bs_o, amx_o, ta_o and grant_o are 0 and rdata_o is 0.
- R2: A write of mr_wdata with mr_we high acts on the opcode in bits [31:30]: 01 stores mdr_i into the array word addressed by bits [5:0]; 10 loads that word into rdata_o, valid in the next cycle; 00 changes only the options. Every mode write also stores the hold length from bits [10:8] and the wait-input select from bit 12.
- R3: Opcode 11 starts a pattern at the word addressed by bits [5:0], with its first word on the outputs in the next cycle; grant_o stays 0 for such a pattern.
- R4: A start happens when acc_req is high in a cycle with no pattern running and no other start pending. The first word then appears in the next cycle with grant_o high. acc_kind 0, 1, 2 and 3 start at word 0, 8, 24 and 32.
- R5: In each cycle of a pattern, the current word drives the outputs: bs_o from bits [7:0], cs_o from bit 8, amx_o from bits [10:9] and ta_o from bit 11. Bits above 16 have no effect.
- R6: A word's repeat field in bits [15:14] holds it on the outputs for field+1 cycles before the next word.
- R7: The end bit (bit 12) finishes the pattern at the end of that cycle. If a start is pending, the next pattern's first word follows with no idle cycle; otherwise the outputs are idle in the next cycle. A word that carries both ta and the end bit gives a single-cycle access.
- R8: When the hold-off bit (bit 13) is set in a word that also has the end bit, exactly hold+1 idle cycles follow before any new pattern starts. In a word without the end bit, the hold-off bit is ignored.
- R9: A word with its wait bit (bit 16) set stays on the outputs for as long as wait_i[select] is high. The wait input that is not selected has no effect.
- R10: A write to the refresh period (rt_we) with a nonzero value raises a refresh request every period cycles, and each request runs the pattern at word 48. A period of 0 stops all requests.
- R11: At a pattern boundary, a pending refresh is started before a manual run, and a manual run before a bus access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mr_we | input | 1 | Mode register write strobe |
| mr_wdata | input | 32 | Mode register value: opcode, word address, hold length, wait select |
| mdr_i | input | WORD_W | Control word to be stored by an array write |
| rt_we | input | 1 | Refresh period write strobe |
| rt_wdata | input | RT_W | Refresh period in cycles, 0 disables |
| acc_req | input | 1 | Bus access request, held until grant |
| acc_kind | input | 2 | Access type: single read, burst read, single write, burst write |
| wait_i | input | 2 | Two external wait inputs |
| cs_o | output | 1 | Chip-select |
| bs_o | output | BS_W | Byte strobes |
| amx_o | output | 2 | Address multiplexer select |
| ta_o | output | 1 | Transfer acknowledge, active high |
| grant_o | output | 1 | High in the first cycle of a bus access pattern |
| rdata_o | output | WORD_W | Array word returned by a read command |

## Verification
Two events can fall in the same cycle: a refresh request arriving, and a pattern boundary at which a bus access is waiting. The bench provokes this by holding acc_req high over several hundred cycles with a short refresh period, so that refresh ticks land at random points inside back-to-back accesses. It judges the result as follows. Every refresh word must directly follow the last word of an access and be followed directly by the next access, with no idle cycle. The number of refreshes must match the elapsed time divided by the period. The wait stall is also combined with the end of a pattern, and the hold-off timer with a request held high, so that each overlap has a defined expected gap.

// File: rtl/mcyc_seq_pkg.sv
package mcyc_seq_pkg;

   typedef enum logic [1:0] {
      OP_CFG = 2'b00,
      OP_WR  = 2'b01,
      OP_RD  = 2'b10,
      OP_RUN = 2'b11
   } mr_op_t;

   localparam int OFS_SRD = 0;
   localparam int OFS_BRD = 8;
   localparam int OFS_SWR = 24;
   localparam int OFS_BWR = 32;
   localparam int OFS_RFS = 48;

   localparam int MR_HOLD_LSB = 8;
   localparam int MR_WSEL_BIT = 12;
   localparam int MR_OP_LSB   = 30;

endpackage

// File: rtl/mcyc_seq_array.sv
module mcyc_seq_array #(
   parameter int ADDR_W = 6,
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [WORD_W-1:0] wdata_i,
   input  logic [ADDR_W-1:0] seq_addr_i,
   output logic [WORD_W-1:0] seq_word_o,
   input  logic              rd_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [WORD_W-1:0] rd_data_o
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DEPTH-1:0][WORD_W-1:0] rows;

   for (genvar g = 0; g < DEPTH; g++) begin : g_row
      logic [WORD_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (we_i && (waddr_i == ADDR_W'(g)))
            q <= wdata_i;
      end
      assign rows[g] = q;
   end

   assign seq_word_o = rows[seq_addr_i];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_data_o <= '0;
      else if (rd_i)
         rd_data_o <= rows[rd_addr_i];
   end
endmodule

// File: rtl/mcyc_seq_rtimer.sv
module mcyc_seq_rtimer #(
   parameter int RT_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we_i,
   input  logic [RT_W-1:0] period_i,
   output logic            tick_o
);
   logic [RT_W-1:0] per_q;
   logic [RT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_q  <= '0;
         cnt_q  <= '0;
         tick_o <= 1'b0;
      end else if (we_i) begin
         per_q  <= period_i;
         cnt_q  <= period_i;
         tick_o <= 1'b0;
      end else if (per_q == '0) begin
         tick_o <= 1'b0;
      end else if (cnt_q <= RT_W'(1)) begin
         cnt_q  <= per_q;
         tick_o <= 1'b1;
      end else begin
         cnt_q  <= cnt_q - RT_W'(1);
         tick_o <= 1'b0;
      end
   end
endmodule

// File: rtl/mcyc_seq_engine.sv
module mcyc_seq_engine
   import mcyc_seq_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int WORD_W = 32,
   parameter int BS_W   = 8,
   parameter int HOLD_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] word_i,
   input  logic              wait_hit_i,
   input  logic              rf_tick_i,
   input  logic              run_cmd_i,
   input  logic [ADDR_W-1:0] run_addr_i,
   input  logic              acc_req_i,
   input  logic [1:0]        acc_kind_i,
   input  logic [HOLD_W-1:0] hold_i,
   output logic [ADDR_W-1:0] ptr_o,
   output logic              act_o,
   output logic              dt_zero_o,
   output logic              grant_o,
   output logic              cs_o,
   output logic [BS_W-1:0]   bs_o,
   output logic [1:0]        amx_o,
   output logic              ta_o
);
   localparam int F_CS   = BS_W;
   localparam int F_AMX  = BS_W + 1;
   localparam int F_TA   = BS_W + 3;
   localparam int F_LAST = BS_W + 4;
   localparam int F_TODT = BS_W + 5;
   localparam int F_REP  = BS_W + 6;
   localparam int F_WAIT = BS_W + 8;

   logic [1:0]        rep_q;
   logic [HOLD_W-1:0] dt_q;
   logic              rf_pend_q, run_pend_q;
   logic [ADDR_W-1:0] run_addr_q;

   logic stall, rep_done, finish, end_hold, slot;
   logic run_want, go_rf, go_run, go_acc, go;
   logic [ADDR_W-1:0] acc_ofs, run_ofs, go_ofs;
   logic unused_word;

   assign unused_word = ^word_i;

   assign stall    = act_o && word_i[F_WAIT] && wait_hit_i;
   assign rep_done = (rep_q == word_i[F_REP +: 2]);
   assign finish   = act_o && !stall && rep_done && word_i[F_LAST];
   assign end_hold = finish && word_i[F_TODT];
   assign slot     = (!act_o || finish) && (dt_q == '0) && !end_hold;

   assign run_want = run_pend_q || run_cmd_i;
   assign go_rf    = slot && rf_pend_q;
   assign go_run   = slot && !rf_pend_q && run_want;
   assign go_acc   = slot && !rf_pend_q && !run_want && acc_req_i;
   assign go       = go_rf || go_run || go_acc;

   always_comb begin
      unique case (acc_kind_i)
         2'd0:    acc_ofs = ADDR_W'(OFS_SRD);
         2'd1:    acc_ofs = ADDR_W'(OFS_BRD);
         2'd2:    acc_ofs = ADDR_W'(OFS_SWR);
         default: acc_ofs = ADDR_W'(OFS_BWR);
      endcase
      run_ofs = run_cmd_i ? run_addr_i : run_addr_q;
      if (go_rf)
         go_ofs = ADDR_W'(OFS_RFS);
      else if (go_run)
         go_ofs = run_ofs;
      else
         go_ofs = acc_ofs;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_o      <= 1'b0;
         ptr_o      <= '0;
         rep_q      <= '0;
         dt_q       <= '0;
         rf_pend_q  <= 1'b0;
         run_pend_q <= 1'b0;
         run_addr_q <= '0;
         grant_o    <= 1'b0;
      end else begin
         grant_o <= go_acc;
         if (go) begin
            act_o <= 1'b1;
            ptr_o <= go_ofs;
            rep_q <= '0;
         end else if (finish) begin
            act_o <= 1'b0;
         end else if (act_o && !stall) begin
            if (!rep_done) begin
               rep_q <= rep_q + 2'd1;
            end else begin
               ptr_o <= ptr_o + ADDR_W'(1);
               rep_q <= '0;
            end
         end
         if (end_hold)
            dt_q <= hold_i;
         else if (dt_q != '0)
            dt_q <= dt_q - HOLD_W'(1);
         rf_pend_q <= (rf_pend_q && !go_rf) || rf_tick_i;
         if (go_run)
            run_pend_q <= 1'b0;
         else if (run_cmd_i)
            run_pend_q <= 1'b1;
         if (run_cmd_i)
            run_addr_q <= run_addr_i;
      end
   end

   assign dt_zero_o = (dt_q == '0);
   assign cs_o  = act_o && word_i[F_CS];
   assign bs_o  = act_o ? word_i[BS_W-1:0] : '0;
   assign amx_o = act_o ? word_i[F_AMX +: 2] : 2'b00;
   assign ta_o  = act_o && word_i[F_TA];
endmodule

// File: rtl/mcyc_seq.sv
module mcyc_seq
   import mcyc_seq_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int WORD_W = 32,
   parameter int BS_W   = 8,
   parameter int HOLD_W = 3,
   parameter int RT_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mr_we,
   input  logic [31:0]       mr_wdata,
   input  logic [WORD_W-1:0] mdr_i,
   input  logic              rt_we,
   input  logic [RT_W-1:0]   rt_wdata,
   input  logic              acc_req,
   input  logic [1:0]        acc_kind,
   input  logic [1:0]        wait_i,
   output logic              cs_o,
   output logic [BS_W-1:0]   bs_o,
   output logic [1:0]        amx_o,
   output logic              ta_o,
   output logic              grant_o,
   output logic [WORD_W-1:0] rdata_o
);
   localparam int F_WAIT = BS_W + 8;

   initial begin
      assert (WORD_W >= F_WAIT + 1) else $error("control word too narrow for fields");
      assert (ADDR_W >= 6 && ADDR_W <= MR_HOLD_LSB) else $error("ADDR_W out of range");
      assert (HOLD_W >= 1 && HOLD_W <= MR_WSEL_BIT - MR_HOLD_LSB) else $error("HOLD_W out of range");
   end

   mr_op_t            op;
   logic [ADDR_W-1:0] mr_addr;
   logic [HOLD_W-1:0] hold_q;
   logic              wsel_q;
   logic              wait_hit, rf_tick;
   logic [ADDR_W-1:0] ptr;
   logic [WORD_W-1:0] cur_word;
   logic              eng_act, eng_dt_zero, eng_word_wait;
   logic              unused_mr;

   assign op        = mr_op_t'(mr_wdata[MR_OP_LSB +: 2]);
   assign mr_addr   = mr_wdata[ADDR_W-1:0];
   assign unused_mr = ^mr_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         wsel_q <= 1'b0;
      end else if (mr_we) begin
         hold_q <= mr_wdata[MR_HOLD_LSB +: HOLD_W];
         wsel_q <= mr_wdata[MR_WSEL_BIT];
      end
   end

   assign wait_hit      = wait_i[wsel_q];
   assign eng_word_wait = cur_word[F_WAIT];

   mcyc_seq_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_array (
      .clk        (clk),
      .rst_n      (rst_n),
      .we_i       (mr_we && op == OP_WR),
      .waddr_i    (mr_addr),
      .wdata_i    (mdr_i),
      .seq_addr_i (ptr),
      .seq_word_o (cur_word),
      .rd_i       (mr_we && op == OP_RD),
      .rd_addr_i  (mr_addr),
      .rd_data_o  (rdata_o)
   );

   mcyc_seq_rtimer #(.RT_W(RT_W)) u_rtimer (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_i     (rt_we),
      .period_i (rt_wdata),
      .tick_o   (rf_tick)
   );

   mcyc_seq_engine #(
      .ADDR_W(ADDR_W), .WORD_W(WORD_W), .BS_W(BS_W), .HOLD_W(HOLD_W)
   ) u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .word_i     (cur_word),
      .wait_hit_i (wait_hit),
      .rf_tick_i  (rf_tick),
      .run_cmd_i  (mr_we && op == OP_RUN),
      .run_addr_i (mr_addr),
      .acc_req_i  (acc_req),
      .acc_kind_i (acc_kind),
      .hold_i     (hold_q),
      .ptr_o      (ptr),
      .act_o      (eng_act),
      .dt_zero_o  (eng_dt_zero),
      .grant_o    (grant_o),
      .cs_o       (cs_o),
      .bs_o       (bs_o),
      .amx_o      (amx_o),
      .ta_o       (ta_o)
   );
endmodule

// File: rtl/mcyc_seq_chk.sv
module mcyc_seq_chk #(
   parameter int BS_W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            act,
   input logic            grant,
   input logic            cs,
   input logic [BS_W-1:0] bs,
   input logic [1:0]      amx,
   input logic            ta,
   input logic            dt_zero,
   input logic            word_wait,
   input logic            wait_hit
);
   // R1: the cycle after a reset cycle has no pattern and no grant
   p_reset_idle_r1: assert property (@(posedge clk)
      !rst_n |=> (!act && !grant));

   // R4: grant only marks a cycle in which a pattern runs
   p_grant_in_pattern_r4: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> act);

   // R8: while the disable timer runs, no pattern starts
   p_holdoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !dt_zero |=> !act);

   // R9: a waiting word keeps the outputs frozen
   p_wait_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (act && word_wait && wait_hit) |=> (act && $stable({cs, bs, amx, ta})));
endmodule

bind mcyc_seq mcyc_seq_chk #(.BS_W(BS_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .act       (eng_act),
   .grant     (grant_o),
   .cs        (cs_o),
   .bs        (bs_o),
   .amx       (amx_o),
   .ta        (ta_o),
   .dt_zero   (eng_dt_zero),
   .word_wait (eng_word_wait),
   .wait_hit  (wait_hit)
);

// File: tb/mcyc_seq_tb_top.sv
module mcyc_seq_tb_top;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mr_we = 1'b0;
   logic [31:0] mr_wdata = '0;
   logic [31:0] mdr_i = '0;
   logic        rt_we = 1'b0;
   logic [7:0]  rt_wdata = '0;
   logic        acc_req = 1'b0;
   logic [1:0]  acc_kind = '0;
   logic [1:0]  wait_i = '0;
   logic        cs_o, ta_o, grant_o;
   logic [7:0]  bs_o;
   logic [1:0]  amx_o;
   logic [31:0] rdata_o;

   int n_chk = 0;
   int n_bad = 0;
   logic [2:0] hold_cfg = '0;
   logic       wsel_cfg = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   mcyc_seq dut_i (
      .clk(clk), .rst_n(rst_n), .mr_we(mr_we), .mr_wdata(mr_wdata), .mdr_i(mdr_i),
      .rt_we(rt_we), .rt_wdata(rt_wdata), .acc_req(acc_req), .acc_kind(acc_kind),
      .wait_i(wait_i), .cs_o(cs_o), .bs_o(bs_o), .amx_o(amx_o), .ta_o(ta_o),
      .grant_o(grant_o), .rdata_o(rdata_o)
   );

   function automatic logic [31:0] mk(input logic [7:0] bs, input logic cs, input logic [1:0] amx,
                                      input logic ta, input logic last, input logic todt,
                                      input logic [1:0] rep, input logic wt);
      logic [31:0] w = '0;
      w[7:0] = bs; w[8] = cs; w[10:9] = amx; w[11] = ta;
      w[12] = last; w[13] = todt; w[15:14] = rep; w[16] = wt;
      return w;
   endfunction

   function automatic logic [11:0] out_of(input logic [31:0] w);
      return {w[8], w[7:0], w[10:9], w[11]};
   endfunction

   function automatic logic [31:0] mrv(input logic [1:0] op, input logic [5:0] a);
      logic [31:0] v = '0;
      v[31:30] = op; v[5:0] = a; v[10:8] = hold_cfg; v[12] = wsel_cfg;
      return v;
   endfunction

   function automatic logic [5:0] kind_ofs(input logic [1:0] k);
      case (k)
         2'd0: return 6'd0;
         2'd1: return 6'd8;
         2'd2: return 6'd24;
         default: return 6'd32;
      endcase
   endfunction

   function automatic logic [11:0] obs();
      return {cs_o, bs_o, amx_o, ta_o};
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
      end
   endtask

   task automatic mr_cmd(input logic [1:0] op, input logic [5:0] a);
      mr_wdata = mrv(op, a); mr_we = 1'b1;
      @(negedge clk);
      mr_we = 1'b0;
   endtask

   task automatic wr_word(input logic [5:0] a, input logic [31:0] w);
      mdr_i = w;
      mr_cmd(2'b01, a);
   endtask

   logic [11:0] exp_q [0:31];

   initial begin : main
      int seed;
      seed = $urandom(32'h1D5E);
      repeat (3) @(negedge clk);
      chk("R1 reset outputs", {20'd0, obs()}, 32'd0);
      chk("R1 reset grant", {31'd0, grant_o}, 32'd0);
      chk("R1 reset rdata", rdata_o, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: array write then readback, with directed upper bits
      wr_word(6'd63, 32'hA5C3_0F1E);
      mr_cmd(2'b10, 6'd63);
      chk("R2 readback", rdata_o, 32'hA5C3_0F1E);
      chk("R1 idle after commands", {20'd0, obs()}, 32'd0);

      // Random patterns of every access kind (R4 R5 R6 R7)
      for (int it = 0; it < 40; it++) begin
         logic [1:0] k;
         int len, n;
         k = 2'($urandom);
         len = 1 + ($urandom % 5);
         n = 0;
         for (int i = 0; i < len; i++) begin
            logic [31:0] w;
            w = mk(8'($urandom), 1'($urandom), 2'($urandom), 1'($urandom),
                   (i == len - 1), 1'b0, 2'($urandom), 1'b0);
            w[31:17] = 15'($urandom);
            wr_word(kind_ofs(k) + 6'(i), w);
            for (int r = 0; r <= int'(w[15:14]); r++) begin
               exp_q[n] = out_of(w);
               n++;
            end
            if (i == 0 && it % 8 == 0) begin
               mr_cmd(2'b10, kind_ofs(k));
               chk("R2 random readback", rdata_o, w);
            end
         end
         acc_kind = k; acc_req = 1'b1;
         @(negedge clk);
         acc_req = 1'b0;
         chk("R4 grant on first word", {31'd0, grant_o}, 32'd1);
         chk("R4 R5 first word", {20'd0, obs()}, {20'd0, exp_q[0]});
         for (int i = 1; i < n; i++) begin
            @(negedge clk);
            chk("R5 R6 word stream", {20'd0, obs()}, {20'd0, exp_q[i]});
            if (grant_o) chk("R4 single grant", 32'd1, 32'd0);
         end
         @(negedge clk);
         chk("R7 idle after end", {20'd0, obs()}, 32'd0);
      end

      // R3: manual run at an arbitrary word
      wr_word(6'd40, mk(8'h77, 1'b1, 2'd2, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0));
      mr_cmd(2'b11, 6'd40);
      chk("R3 run first word", {20'd0, obs()}, {20'd0, out_of(mk(8'h77, 1'b1, 2'd2, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0))});
      chk("R3 no grant on run", {31'd0, grant_o}, 32'd0);
      @(negedge clk);
      chk("R3 idle after run", {20'd0, obs()}, 32'd0);

      // R6: repeat field 2 gives three cycles
      wr_word(6'd0, mk(8'h66, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 2'd2, 1'b0));
      acc_kind = 2'd0; acc_req = 1'b1;
      @(negedge clk);
      acc_req = 1'b0;
      for (int i = 0; i < 3; i++) begin
         chk("R6 repeated word", {24'd0, bs_o}, 32'h66);
         @(negedge clk);
      end
      chk("R6 idle after repeats", {20'd0, obs()}, 32'd0);

      // R7: ta and end in one word
      wr_word(6'd0, mk(8'h39, 1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0));
      acc_req = 1'b1;
      @(negedge clk);
      acc_req = 1'b0;
      chk("R7 single-cycle ta", {31'd0, ta_o}, 32'd1);
      @(negedge clk);
      chk("R7 single-cycle then idle", {20'd0, obs()}, 32'd0);

      // R7 R8: back-to-back with hold-off bit in a non-end word
      wr_word(6'd0, mk(8'h22, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0));
      wr_word(6'd1, mk(8'h33, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0));
      acc_req = 1'b1;
      @(negedge clk);
      chk("R7 b2b w0", {24'd0, bs_o}, 32'h22);
      @(negedge clk);
      chk("R7 b2b w1", {24'd0, bs_o}, 32'h33);
      @(negedge clk);
      chk("R8 hold-off ignored without end", {24'd0, bs_o}, 32'h22);
      chk("R7 b2b grant", {31'd0, grant_o}, 32'd1);
      @(negedge clk);
      chk("R7 b2b w1 again", {24'd0, bs_o}, 32'h33);
      acc_req = 1'b0;
      @(negedge clk);
      chk("R7 idle after b2b", {20'd0, obs()}, 32'd0);

      // R8: hold-off with end bit, request held high
      wr_word(6'd0, mk(8'h11, 1'b1, 2'd0, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0));
      foreach (hold_cfg[b]) begin end
      for (int h = 0; h < 8; h += 3) begin
         int gap;
         hold_cfg = 3'(h);
         mr_cmd(2'b00, 6'd0);
         acc_req = 1'b1;
         @(negedge clk);
         chk("R8 first pattern", {24'd0, bs_o}, 32'h11);
         gap = 0;
         for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (obs() != 12'd0) break;
            gap++;
         end
         acc_req = 1'b0;
         chk("R8 hold-off gap", 32'(gap), 32'(h + 1));
         chk("R8 grant after gap", {31'd0, grant_o}, 32'd1);
         repeat (12) @(negedge clk);
      end
      hold_cfg = '0;

      // R9: wait select 1
      wsel_cfg = 1'b1;
      mr_cmd(2'b00, 6'd0);
      wr_word(6'd0, mk(8'h44, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1));
      wr_word(6'd1, mk(8'h55, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0));
      wait_i = 2'b01;
      acc_req = 1'b1;
      @(negedge clk);
      acc_req = 1'b0;
      chk("R9 wait word", {24'd0, bs_o}, 32'h44);
      @(negedge clk);
      chk("R9 unselected wait ignored", {24'd0, bs_o}, 32'h55);
      @(negedge clk);
      chk("R9 idle", {20'd0, obs()}, 32'd0);
      wait_i = 2'b10;
      acc_req = 1'b1;
      @(negedge clk);
      acc_req = 1'b0;
      for (int i = 0; i < 4; i++) begin
         chk("R9 stalled word", {24'd0, bs_o}, 32'h44);
         if (i < 3) @(negedge clk);
      end
      wait_i = 2'b00;
      @(negedge clk);
      chk("R9 advance after release", {24'd0, bs_o}, 32'h55);
      @(negedge clk);
      chk("R9 idle after release", {20'd0, obs()}, 32'd0);
      wsel_cfg = 1'b0;
      mr_cmd(2'b00, 6'd0);

      // R10 R11: refresh against continuous accesses
      wr_word(6'd48, mk(8'h80, 1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0));
      wr_word(6'd0, mk(8'h01, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 2'd3, 1'b0));
      rt_wdata = 8'd20; rt_we = 1'b1;
      @(negedge clk);
      rt_we = 1'b0;
      acc_kind = 2'd0; acc_req = 1'b1;
      begin
         int nref, nidle, bad_pos;
         logic [7:0] prev;
         nref = 0; nidle = 0; bad_pos = 0; prev = 8'h00;
         for (int c = 0; c < 400; c++) begin
            @(negedge clk);
            if (c > 0 && bs_o == 8'h00) nidle++;
            if (bs_o == 8'h80) begin
               nref++;
               if (c > 0 && prev != 8'h01) bad_pos++;
            end
            if (prev == 8'h80 && bs_o != 8'h01) bad_pos++;
            prev = bs_o;
         end
         acc_req = 1'b0;
         chk("R10 refresh count low", 32'(nref >= 19), 32'd1);
         chk("R10 refresh count high", 32'(nref <= 21), 32'd1);
         chk("R11 refresh between accesses", 32'(bad_pos), 32'd0);
         chk("R11 no idle under load", 32'(nidle), 32'd0);
      end
      rt_wdata = 8'd0; rt_we = 1'b1;
      @(negedge clk);
      rt_we = 1'b0;
      repeat (10) @(negedge clk);
      begin
         int nref;
         nref = 0;
         for (int c = 0; c < 100; c++) begin
            @(negedge clk);
            if (bs_o == 8'h80) nref++;
         end
         chk("R10 period zero stops refresh", 32'(nref), 32'd0);
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : watchdog
      #(CLK_P * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule